// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block keeps an asynchronous DRAM of 4096 rows refreshed and brings it up after power-on. From reset it first holds off for a timed startup wait. It then runs a fixed number of warm-up refresh cycles, and only after that raises its ready flag. From then on a free-running interval timer marks the moment each new refresh falls due. On average this is every 15.6 µs, so that all rows are covered within 64 ms.

Every refresh is a CAS-before-RAS cycle. The row address comes from the memory's internal counter, so the address and data pins take no part. The block does not own the memory bus. It raises a request to the access sequencer and waits for a grant, then drives the RAS, both byte CAS strobes and WE for the length of the cycle, with a busy flag marking ownership. A refresh that cannot be granted at once is counted as postponed. Up to eight may be owed. When the count reaches eight, an urgent flag tells the sequencer to cut short any page-mode burst.

All nanosecond limits are parameters. They are turned into clock counts by rounding up against a parameterized clock period.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and just after release, ref_req, ref_urgent, ref_busy and init_done are 0, and ras_n, cas_lo_n, cas_hi_n and we_n are 1.
- R2: No refresh request is raised until ceil(INIT_WAIT_NS / clock period) cycles have passed since reset release; at 100 MHz and 200 µs that is 20000 cycles.
- R3: After the startup wait exactly WARMUP_REFRESHES (8) refresh cycles run, and init_done rises only once the last of them has finished; init_done then stays 1.
- R4: The strobes stay inactive (high) and ref_req stays high while a request is not granted. In the cycle after ref_req and ref_gnt are both 1, ref_busy is 1 and ref_req is 0. Either RAS or CAS low implies ref_busy.
- R5: CAS (active low) falls at least ceil(5 ns) clock cycles before RAS falls, and we_n is 1 while RAS falls.
- R6: RAS stays low at least ceil(50 ns) cycles, CAS stays low at least ceil(10 ns) cycles after RAS falls, and CAS is back high no later than RAS rises.
- R7: RAS stays high at least ceil(30 ns) cycles between refreshes, and successive RAS falling edges are at least ceil(84 ns) cycles apart.
- R8: After init_done, with the grant always given, one refresh is issued per ceil(REFRESH_INTERVAL_NS / clock period) cycles (1560 at the defaults).
- R9: A due refresh that is not granted is remembered. The owed count saturates at PEND_MAX (8), so however long the grant is withheld, at most 8 refreshes are issued once it returns.
- R10: ref_urgent is 1 exactly while PEND_MAX refreshes are owed. It is 0 before init_done, and it falls once one owed refresh has completed.
- R11: cas_lo_n and cas_hi_n are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access sequencer, sampled while a request is open |
| ref_req | output | 1 | A refresh cycle (warm-up or periodic) is waiting for the bus |
| ref_urgent | output | 1 | The owed-refresh count is at its limit |
| ref_busy | output | 1 | A refresh cycle owns the strobes |
| init_done | output | 1 | Startup wait and warm-up refreshes are complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| we_n | output | 1 | Write enable, held high for every refresh |

## Verification
The scheduler is tried with four grant patterns. An immediate grant during warm-up separates a correct warm-up count and ready timing from an early or late ready flag. A grant held back on the first request shows whether the block waits for ownership or drives the strobes without it. A grant that is always present after ready shows the refresh rate, where a wrong interval produces too many or too few cycles in a fixed window. A grant withheld for more than eight intervals and then released separates a saturating owed-refresh count from one that wraps or overruns, and shows that the urgent flag falls after one repayment. Every strobe edge in all these patterns is measured in cycles against the CAS lead, RAS width, CAS hold, precharge and cycle-time minimums.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_IDLE,
        ST_CSR,
        ST_RAS,
        ST_PRE
    } seq_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = dref_pkg::imax($clog2(PERIOD), 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_q, tmr_d;
    logic wrap;

    assign wrap = run && (tmr_q.cnt == CW'(PERIOD - 1));
    assign tick = wrap;

    always_comb begin
        tmr_d = tmr_q;
        if (!run || wrap) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/dref_pending_ctr.sv
module dref_pending_ctr #(
    parameter int MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic full
);
    localparam int CW = dref_pkg::imax($clog2(MAX + 1), 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pend_s;

    pend_s pend_q, pend_d;

    assign nonzero = (pend_q.cnt != '0);
    assign full    = (pend_q.cnt == CW'(MAX));

    always_comb begin
        pend_d = pend_q;
        if (inc && !dec && !full) begin
            pend_d.cnt = pend_q.cnt + 1'b1;
        end else if (dec && !inc && nonzero) begin
            pend_d.cnt = pend_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/dref_cycle_fsm.sv
module dref_cycle_fsm
    import dref_pkg::*;
#(
    parameter int INIT_CYC = 20000,
    parameter int WARMUP   = 8,
    parameter int CSR_CYC  = 1,
    parameter int CHR_CYC  = 1,
    parameter int RAS_CYC  = 5,
    parameter int PRE_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic work_pending,
    input  logic gnt,
    output logic req,
    output logic busy,
    output logic init_done,
    output logic ref_done,
    output logic ras_n,
    output logic cas_n
);
    localparam int LONGEST = imax(INIT_CYC, imax(CSR_CYC, imax(RAS_CYC, PRE_CYC)));
    localparam int CW      = imax($clog2(LONGEST + 1), 1);
    localparam int WW      = imax($clog2(WARMUP + 1), 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [WW-1:0] warm;
        logic          init_done;
        logic          ras_n;
        logic          cas_n;
    } fsm_s;

    fsm_s fsm_q, fsm_d;
    logic pre_last;

    assign pre_last  = (fsm_q.state == ST_PRE) && (fsm_q.cnt == CW'(PRE_CYC - 1));
    assign req       = (fsm_q.state == ST_IDLE) && ((fsm_q.warm != '0) || work_pending);
    assign busy      = (fsm_q.state == ST_CSR) || (fsm_q.state == ST_RAS) || (fsm_q.state == ST_PRE);
    assign init_done = fsm_q.init_done;
    assign ref_done  = pre_last && (fsm_q.warm == '0);
    assign ras_n     = fsm_q.ras_n;
    assign cas_n     = fsm_q.cas_n;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_WAIT: begin
                if (fsm_q.cnt == CW'(INIT_CYC - 1)) begin
                    fsm_d.state = ST_IDLE;
                    fsm_d.cnt   = '0;
                    if (WARMUP == 0) fsm_d.init_done = 1'b1;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (req && gnt) begin
                    fsm_d.state = ST_CSR;
                    fsm_d.cnt   = '0;
                end
            end
            ST_CSR: begin
                if (fsm_q.cnt == CW'(CSR_CYC - 1)) begin
                    fsm_d.state = ST_RAS;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_RAS: begin
                if (fsm_q.cnt == CW'(RAS_CYC - 1)) begin
                    fsm_d.state = ST_PRE;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_PRE: begin
                if (pre_last) begin
                    fsm_d.state = ST_IDLE;
                    fsm_d.cnt   = '0;
                    if (fsm_q.warm != '0) begin
                        fsm_d.warm = fsm_q.warm - 1'b1;
                        if (fsm_q.warm == WW'(1)) fsm_d.init_done = 1'b1;
                    end
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: begin
                fsm_d.state = ST_IDLE;
                fsm_d.cnt   = '0;
            end
        endcase
        // Strobes are registered from the next state so the pins never glitch.
        fsm_d.ras_n = (fsm_d.state != ST_RAS);
        fsm_d.cas_n = !((fsm_d.state == ST_CSR) ||
                        ((fsm_d.state == ST_RAS) && (fsm_d.cnt < CW'(CHR_CYC))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.state     <= ST_WAIT;
            fsm_q.cnt       <= '0;
            fsm_q.warm      <= WW'(WARMUP);
            fsm_q.init_done <= 1'b0;
            fsm_q.ras_n     <= 1'b1;
            fsm_q.cas_n     <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int CLK_PERIOD_PS       = 10000,
    parameter int INIT_WAIT_NS        = 200000,
    parameter int REFRESH_INTERVAL_NS = 15600,
    parameter int WARMUP_REFRESHES    = 8,
    parameter int PEND_MAX            = 8,
    parameter int T_CSR_NS            = 5,
    parameter int T_CHR_NS            = 10,
    parameter int T_RAS_NS            = 50,
    parameter int T_RP_NS             = 30,
    parameter int T_RC_NS             = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic init_done,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic we_n
);
    localparam int INIT_CYC = ns_to_cyc(INIT_WAIT_NS, CLK_PERIOD_PS);
    localparam int TREF_CYC = ns_to_cyc(REFRESH_INTERVAL_NS, CLK_PERIOD_PS);
    localparam int CSR_CYC  = ns_to_cyc(T_CSR_NS, CLK_PERIOD_PS);
    localparam int RAS_CYC  = ns_to_cyc(T_RAS_NS, CLK_PERIOD_PS);
    localparam int CHR_CYC  = imin(ns_to_cyc(T_CHR_NS, CLK_PERIOD_PS), RAS_CYC);
    localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS);
    localparam int PRE_CYC  = imax(RP_CYC, RC_CYC - RAS_CYC);

    logic tick, owed_nz, owed_full, ref_done, cas_n;

    dref_interval_timer #(
        .PERIOD (TREF_CYC)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_done),
        .tick  (tick)
    );

    dref_pending_ctr #(
        .MAX (PEND_MAX)
    ) owed_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (ref_done),
        .nonzero (owed_nz),
        .full    (owed_full)
    );

    dref_cycle_fsm #(
        .INIT_CYC (INIT_CYC),
        .WARMUP   (WARMUP_REFRESHES),
        .CSR_CYC  (CSR_CYC),
        .CHR_CYC  (CHR_CYC),
        .RAS_CYC  (RAS_CYC),
        .PRE_CYC  (PRE_CYC)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .work_pending (owed_nz),
        .gnt          (ref_gnt),
        .req          (ref_req),
        .busy         (ref_busy),
        .init_done    (init_done),
        .ref_done     (ref_done),
        .ras_n        (ras_n),
        .cas_n        (cas_n)
    );

    assign ref_urgent = owed_full;
    assign cas_lo_n   = cas_n;
    assign cas_hi_n   = cas_n;
    assign we_n       = 1'b1;
endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_urgent,
    input logic ref_busy,
    input logic init_done,
    input logic ras_n,
    input logic cas_lo_n,
    input logic cas_hi_n,
    input logic we_n
);
    // R4: a strobe is only active while the block owns the bus
    a_r4_strobes_need_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_lo_n) |-> ref_busy);

    // R4: a granted request turns into ownership on the next cycle
    a_r4_grant_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (ref_busy && !ref_req));

    // R5: CAS already low in the cycle before RAS falls, WE high
    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (($past(cas_lo_n) == 1'b0) && we_n));

    // R6: CAS is high again by the time RAS rises
    a_r6_cas_up_by_ras_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_lo_n);

    // R10: no urgency before the memory is ready
    a_r10_no_urgent_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_urgent);

    // R10: an urgent backlog is always either requesting or being served
    a_r10_urgent_served: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req || ref_busy));
endmodule

bind dram_refresh_sched dref_sched_chk chk_i (.*);

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
    localparam int INIT_CYC = 20000;
    localparam int TREF     = 1560;
    localparam int CSR      = 1;
    localparam int CHR      = 1;
    localparam int RASW     = 5;
    localparam int RP       = 3;
    localparam int RC       = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_urgent, ref_busy, init_done, ras_n, cas_lo_n, cas_hi_n, we_n;

    int n_checks = 0;
    int n_errors = 0;
    int ref_seen = 0;
    int pair_bad = 0;

    always #5 clk = ~clk;

    dram_refresh_sched dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .ref_busy   (ref_busy),
        .init_done  (init_done),
        .ras_n      (ras_n),
        .cas_lo_n   (cas_lo_n),
        .cas_hi_n   (cas_hi_n),
        .we_n       (we_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe timing monitor, sampled on the falling clock edge
    int  cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, since_fall = 0, chr_run = 0;
    logic prev_ras = 1'b1;
    bit  seen_fall = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cas_lo_n !== cas_hi_n) pair_bad++;
            if (prev_ras === 1'b1 && ras_n === 1'b0) begin
                ref_seen++;
                chk(cas_low_run >= CSR, "R5 cas lead cycles", cas_low_run, CSR);
                chk(we_n === 1'b1, "R5 we_n at ras fall", we_n, 1);
                if (seen_fall) begin
                    chk(since_fall >= RC, "R7 ras fall spacing", since_fall, RC);
                    chk(ras_high_run >= RP, "R7 precharge cycles", ras_high_run, RP);
                end
                seen_fall  = 1'b1;
                since_fall = 0;
            end
            if (prev_ras === 1'b0 && ras_n === 1'b1) begin
                chk(ras_low_run >= RASW, "R6 ras low cycles", ras_low_run, RASW);
                chk(chr_run >= CHR, "R6 cas hold after ras fall", chr_run, CHR);
                chk(cas_lo_n === 1'b1, "R6 cas high at ras rise", cas_lo_n, 1);
            end
            cas_low_run  = cas_lo_n ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            if (ras_n) chr_run = 0;
            else if (!cas_lo_n) chr_run = chr_run + 1;
            since_fall++;
            prev_ras = ras_n;
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ref_req == 0 && ref_busy == 0, "R1 req/busy in reset", {ref_req, ref_busy}, 0);
        chk(init_done == 0 && ref_urgent == 0, "R1 flags in reset", {init_done, ref_urgent}, 0);
        chk({ras_n, cas_lo_n, cas_hi_n, we_n} == 4'hF, "R1 strobes in reset",
            {ras_n, cas_lo_n, cas_hi_n, we_n}, 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ref_req == 0 && init_done == 0 && ras_n == 1, "R1 state after release",
            {ref_req, init_done, ras_n}, 1);
    endtask

    task automatic t_init_wait();
        int waited = 1;
        while (!ref_req && waited < INIT_CYC + 50) begin
            @(negedge clk);
            waited++;
        end
        chk(waited >= INIT_CYC, "R2 startup wait not too short", waited, INIT_CYC);
        chk(waited <= INIT_CYC + 2, "R2 startup wait not too long", waited, INIT_CYC);
    endtask

    task automatic t_grant_handshake();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 9) begin
                chk(ref_req == 1, "R4 request held without grant", ref_req, 1);
                chk(ras_n == 1 && cas_lo_n == 1 && ref_busy == 0, "R4 idle strobes without grant",
                    {ras_n, cas_lo_n, ref_busy}, 6);
            end
        end
        ref_gnt = 1'b1;
        @(negedge clk);
        chk(ref_busy == 1 && ref_req == 0, "R4 ownership after grant", {ref_busy, ref_req}, 2);
        chk(cas_lo_n == 0 && ras_n == 1, "R5 cas first after grant", {cas_lo_n, ras_n}, 1);
    endtask

    task automatic t_warmup();
        int t = 0;
        while (!init_done && t < 500) begin
            chk(ref_urgent == 0, "R10 no urgent during warm-up", ref_urgent, 0);
            @(negedge clk);
            t++;
        end
        chk(ref_seen == 8, "R3 warm-up refresh count", ref_seen, 8);
        chk(init_done == 1 && ras_n == 1, "R3 ready after last warm-up", {init_done, ras_n}, 3);
    endtask

    task automatic t_periodic();
        int base = ref_seen;
        repeat (4 * TREF + 20) @(negedge clk);
        chk(ref_seen - base == 4, "R8 refreshes in four intervals", ref_seen - base, 4);
        chk(init_done == 1, "R3 ready stays high", init_done, 1);
        chk(ref_urgent == 0, "R10 no urgency when served", ref_urgent, 0);
    endtask

    task automatic t_postpone();
        int t = 0;
        int base;
        ref_gnt = 1'b0;
        while (!ref_urgent && t < 9 * TREF + 100) begin
            @(negedge clk);
            t++;
        end
        chk(ref_urgent == 1, "R10 urgent after eight owed", ref_urgent, 1);
        chk(t > 7 * TREF && t <= 8 * TREF + 5, "R10 urgent timing", t, 8 * TREF);
        chk(ref_seen >= 0 && ras_n == 1, "R4 no cycle while withheld", ras_n, 1);
        repeat (2 * TREF + 50) @(negedge clk);
        chk(ref_urgent == 1, "R9 still saturated", ref_urgent, 1);
        base = ref_seen;
        ref_gnt = 1'b1;
        while (ras_n) @(negedge clk);
        while (!ras_n) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(ref_urgent == 0, "R10 urgent drops after one repayment", ref_urgent, 1'b0);
        repeat (200) @(negedge clk);
        chk(ref_seen - base == 8, "R9 owed refreshes capped", ref_seen - base, 8);
        chk(ref_req == 0, "R9 backlog cleared", ref_req, 0);
        chk(pair_bad == 0, "R11 byte strobes identical", pair_bad, 0);
    endtask

    initial begin
        t_reset();
        t_init_wait();
        t_grant_handshake();
        t_warmup();
        t_periodic();
        t_postpone();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule